// File: doc/BRIEF.md
# Two-Bit Burst Address Generator

This block supplies the array address for a synchronous burst memory. An address can be captured from either of two sources. One is a processor-side address with its own strobe. The other is a controller-side address with its own strobe. The captured value appears on `cur_addr` one clock later, and `burst_active` rises at the same time. After that, each cycle with `advance` high steps only the two lowest address bits to the next beat of a four-beat burst. All higher bits stay as they were captured.

The `order_sel` input chooses the beat order and is held steady between resets. A high level gives linear order: the low bits count upward from the captured value and wrap modulo four. A low level gives interleaved order: the low bits are the captured low bits XOR the beat number (0 to 3). Interleaved is the zero-level default. Bursting is optional, because a fresh address may be captured on every clock.

Top module: `bag_burst_addr`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, `cur_addr` is 0 and `burst_active` is 0.
- R2: When `proc_strobe` is high at a clock edge, `cur_addr` equals the `proc_addr` value sampled at that edge from the next cycle on, and the beat number restarts at 0.
- R3: When `ctrl_strobe` is high and `proc_strobe` is low at an edge, `cur_addr` takes the sampled `ctrl_addr` value in the next cycle.
- R4: When both strobes are high at the same edge, the processor-side address is captured and the controller-side address is ignored.
- R5: Any capture sets `burst_active` to 1 in the next cycle. Either strobe takes precedence over `advance`.
- R6: At an edge with both strobes and `advance` low, `cur_addr` and `burst_active` keep their values.
- R7: With `order_sel` = 1 (linear), an advance makes the low two bits equal to the captured low bits plus the beat number, modulo 4. Each advance therefore adds 1 to bits [1:0].
- R8: With `order_sel` = 0 (interleaved), an advance makes the low two bits equal to the captured low bits XOR the beat number.
- R9: Bits [ADDR_W-1:2] of `cur_addr` change only on a capture. An advance never carries into them.
- R10: The advance after the fourth beat (beat 3) returns the low bits to their captured value and clears `burst_active`. Later advances keep cycling through the same four beats with `burst_active` low.
- R11: Captures on consecutive edges each take effect, with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| proc_strobe | input | 1 | Capture strobe, processor side (higher priority) |
| proc_addr | input | ADDR_W | Processor-side address |
| ctrl_strobe | input | 1 | Capture strobe, controller side |
| ctrl_addr | input | ADDR_W | Controller-side address |
| advance | input | 1 | Step to the next beat |
| order_sel | input | 1 | 1 = linear order, 0 = interleaved order |
| cur_addr | output | ADDR_W | Current array address |
| burst_active | output | 1 | High from a capture until the burst wraps |

## Verification
The assertions assume that `order_sel` changes only while `rst_n` is low. The hold and linear-step properties compare the combinational low bits across cycles, so a mode change in mid-burst would break them. The bench therefore selects each order inside a reset pulse and keeps it for the whole run that follows. Between those resets, strobes, advances and both address buses are driven freely. The runs include both-strobe collisions, back-to-back captures and long advance streaks that pass the wrap.

// File: rtl/bag_pkg.sv
package bag_pkg;

    typedef enum logic {
        ORD_INTERLEAVE = 1'b0,
        ORD_LINEAR     = 1'b1
    } bag_order_e;

    // Low address bits for a given captured start and beat number.
    function automatic logic [1:0] bag_low_bits(
        input logic [1:0] start,
        input logic [1:0] beat,
        input bag_order_e order
    );
        logic [1:0] r;
        if (order == ORD_LINEAR) r = start + beat;
        else                     r = start ^ beat;
        return r;
    endfunction

endpackage

// File: rtl/bag_strobe_sel.sv
module bag_strobe_sel #(
    parameter int ADDR_W = 20
) (
    input  logic              proc_strobe,
    input  logic [ADDR_W-1:0] proc_addr,
    input  logic              ctrl_strobe,
    input  logic [ADDR_W-1:0] ctrl_addr,
    output logic              load,
    output logic [ADDR_W-1:0] load_addr
);
    // The processor side wins when both strobes are high.
    always_comb begin
        load      = proc_strobe | ctrl_strobe;
        load_addr = proc_strobe ? proc_addr : ctrl_addr;
    end
endmodule

// File: rtl/bag_low_map.sv
module bag_low_map
    import bag_pkg::*;
(
    input  logic [1:0] start,
    input  logic [1:0] beat,
    input  logic       order_sel,
    output logic [1:0] low
);
    always_comb begin
        low = bag_low_bits(start, beat, bag_order_e'(order_sel));
    end
endmodule

// File: rtl/bag_burst_addr.sv
module bag_burst_addr #(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              proc_strobe,
    input  logic [ADDR_W-1:0] proc_addr,
    input  logic              ctrl_strobe,
    input  logic [ADDR_W-1:0] ctrl_addr,
    input  logic              advance,
    input  logic              order_sel,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              burst_active
);
    localparam int HI_W = ADDR_W - 2;
    localparam logic [1:0] LAST_BEAT = 2'd3;

    typedef struct packed {
        logic [HI_W-1:0] hi;
        logic [1:0]      start;
        logic [1:0]      beat;
        logic            active;
    } bag_state_t;

    bag_state_t s_d, s_q;
    logic              load;
    logic [ADDR_W-1:0] load_addr;
    logic [1:0]        low;

    bag_strobe_sel #(.ADDR_W(ADDR_W)) u_sel (
        .proc_strobe (proc_strobe),
        .proc_addr   (proc_addr),
        .ctrl_strobe (ctrl_strobe),
        .ctrl_addr   (ctrl_addr),
        .load        (load),
        .load_addr   (load_addr)
    );

    bag_low_map u_map (
        .start     (s_q.start),
        .beat      (s_q.beat),
        .order_sel (order_sel),
        .low       (low)
    );

    always_comb begin
        s_d = s_q;
        if (load) begin
            s_d.hi     = load_addr[ADDR_W-1:2];
            s_d.start  = load_addr[1:0];
            s_d.beat   = '0;
            s_d.active = 1'b1;
        end else if (advance) begin
            s_d.beat = s_q.beat + 2'd1;
            if (s_q.beat == LAST_BEAT) s_d.active = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cur_addr     = {s_q.hi, low};
    assign burst_active = s_q.active;

    // Assertions (order_sel is held steady between resets)
    a_r2_proc_load: assert property (@(posedge clk) disable iff (!rst_n)
        proc_strobe |=> cur_addr == $past(proc_addr));

    a_r4_proc_priority: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_strobe && ctrl_strobe) |=> cur_addr != $past(ctrl_addr) || $past(ctrl_addr) == $past(proc_addr));

    a_r3_ctrl_load: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_strobe && !proc_strobe) |=> cur_addr == $past(ctrl_addr));

    a_r5_active_set: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_strobe || ctrl_strobe) |=> burst_active);

    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!proc_strobe && !ctrl_strobe && !advance) |=> $stable(cur_addr) && $stable(burst_active));

    a_r7_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
        (order_sel && advance && !proc_strobe && !ctrl_strobe)
        |=> cur_addr[1:0] == $past(cur_addr[1:0]) + 2'd1);

    a_r9_upper_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!proc_strobe && !ctrl_strobe) |=> $stable(cur_addr[ADDR_W-1:2]));

    a_r10_no_rise_on_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (!proc_strobe && !ctrl_strobe && !burst_active) |=> !burst_active);

endmodule

// File: tb/tb_bag_burst_addr.sv
module tb_bag_burst_addr;
    localparam int AW = 20;
    localparam int TIMEOUT_CYC = 20000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          proc_strobe = 1'b0;
    logic [AW-1:0] proc_addr = '0;
    logic          ctrl_strobe = 1'b0;
    logic [AW-1:0] ctrl_addr = '0;
    logic          advance = 1'b0;
    logic          order_sel = 1'b0;
    logic [AW-1:0] cur_addr;
    logic          burst_active;

    int n_cmp = 0;
    int n_bad = 0;

    // Behavioural reference state
    logic [AW-1:0] m_base;
    int            m_beat;
    bit            m_act;

    always #10 clk = ~clk;   // 50 MHz

    bag_burst_addr #(.ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n),
        .proc_strobe(proc_strobe), .proc_addr(proc_addr),
        .ctrl_strobe(ctrl_strobe), .ctrl_addr(ctrl_addr),
        .advance(advance), .order_sel(order_sel),
        .cur_addr(cur_addr), .burst_active(burst_active)
    );

    function automatic logic [AW-1:0] model_addr();
        int lo;
        int st;
        st = int'(m_base[1:0]);
        if (order_sel) lo = (st + m_beat) % 4;
        else           lo = st ^ m_beat;
        return {m_base[AW-1:2], 2'(lo)};
    endfunction

    task automatic compare(string tag);
        logic [AW-1:0] exp_a;
        exp_a = model_addr();
        n_cmp++;
        if (cur_addr !== exp_a || burst_active !== m_act) begin
            n_bad++;
            $display("FAIL %s: addr=%h act=%b expected addr=%h act=%b",
                     tag, cur_addr, burst_active, exp_a, m_act);
        end
    endtask

    // One clock: drive, let the edge pass, update model, check at negedge.
    task automatic step(bit p, bit c, bit a, logic [AW-1:0] pa, logic [AW-1:0] ca, string tag);
        proc_strobe = p; ctrl_strobe = c; advance = a;
        proc_addr = pa;  ctrl_addr = ca;
        @(posedge clk);
        if (p) begin
            m_base = pa; m_beat = 0; m_act = 1'b1;
        end else if (c) begin
            m_base = ca; m_beat = 0; m_act = 1'b1;
        end else if (a) begin
            if (m_beat == 3) m_act = 1'b0;
            m_beat = (m_beat + 1) % 4;
        end
        @(negedge clk);
        compare(tag);
    endtask

    task automatic do_reset(bit ord);
        rst_n = 1'b0;
        proc_strobe = 0; ctrl_strobe = 0; advance = 0;
        order_sel = ord;
        m_base = '0; m_beat = 0; m_act = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        compare("R1 reset");
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        compare("R1 after reset");
    endtask

    task automatic mode_run(bit ord);
        do_reset(ord);
        step(1, 0, 0, 20'hABCD6, 20'h11111, "R2 proc load");
        step(0, 0, 0, 20'h0, 20'h0, "R6 hold");
        for (int i = 0; i < 6; i++)
            step(0, 0, 1, 20'h0, 20'h0, ord ? "R7 R9 R10 linear advance" : "R8 R9 R10 interleaved advance");
        step(0, 1, 0, 20'h0, 20'h5A5A3, "R3 ctrl load");
        step(0, 0, 1, 20'h0, 20'h0, ord ? "R7 advance" : "R8 advance");
        step(1, 1, 1, 20'h0F0F1, 20'h3C3C2, "R4 both strobes");
        step(0, 1, 1, 20'h0, 20'h7FFFF, "R5 strobe over advance");
        for (int i = 0; i < 5; i++)
            step(0, 0, 1, 20'h0, 20'h0, "R9 R10 no carry at top");
        step(1, 0, 0, 20'h00001, 20'h0, "R11 back-to-back");
        step(0, 1, 0, 20'h0, 20'h00002, "R11 back-to-back");
        step(1, 0, 0, 20'hFFFFF, 20'h0, "R11 back-to-back");
        for (int i = 0; i < 400; i++) begin
            int r;
            r = $urandom_range(0, 15);
            step(r == 0, r == 1 || r == 2, r >= 6, AW'($urandom), AW'($urandom),
                 "R2 R3 R4 R6 R7 R8 R10 random mix");
        end
    endtask

    initial begin
        fork
            begin
                mode_run(1'b1);
                mode_run(1'b0);
            end
            begin
                repeat (TIMEOUT_CYC) @(posedge clk);
                n_bad++;
                $display("FAIL watchdog: run did not finish, expected completion");
            end
        join_any
        disable fork;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule